// File: doc/BRIEF.md
# Serial GPIO Backplane Frame Receiver

This block sits on the backplane side of a four-wire serial GPIO link. The initiator drives a serial clock, a load strobe and an outbound data line. The block drives the inbound data line back. The serial wires are brought into the system clock domain through a two-flop synchronizer, and edges of the serial clock are detected there. Outbound data and the strobe are sampled on each falling serial edge. The stream is cut into three-bit groups, one group per drive slot. Each group carries an activity bit, a locate bit and a fail bit.

A frame ends with the bit that is sampled while the load strobe is high. If the frame held exactly three bits per configured slot, all per-slot outputs are replaced together and a one-cycle completion pulse is raised. A frame of any other length is dropped and raises a one-cycle error pulse. On every rising serial edge during the same frame, the block launches one bit of per-slot target status on the inbound line. The inbound line can be tied off with a parameter.

Top module: `sgpio_rx`

## Requirements
- R1: While reset is low and directly after it, every per-slot output, `frame_ok`, `frame_err` and `sdin` is 0.
- R2: The k-th bit sampled in a frame (k from 0) belongs to slot k/3. Its field is given by k mod 3: 0 is activity (`act`), 1 is locate (`loc`) and 2 is fail (`fail`).
- R3: A frame ends on the bit sampled with `sload` high. If it held exactly 3*NSLOT bits, `act`, `loc` and `fail` all take the new frame's bits in the same cycle, and `frame_ok` is high for exactly that one cycle.
- R4: A frame that ends with fewer or more than 3*NSLOT bits raises `frame_err` for one cycle and leaves `act`, `loc` and `fail` unchanged.
- R5: Bits sampled before the first `sload` high after reset are discarded. That first frame raises neither `frame_ok` nor `frame_err`.
- R6: `act`, `loc` and `fail` change only in a cycle where `frame_ok` is high.
- R7: With HAS_IN=1, each rising serial edge drives `sdin` to `tgt_status[k]`, where k is the number of bits already sampled in the current frame. `sdin` is 0 once k reaches 3*NSLOT. Bit k of `tgt_status` belongs to slot k/3, field k mod 3.
- R8: With HAS_IN=0, `sdin` stays 0 whatever the inputs do.
- R9: When an `sclk` edge arrives at the input, the results it causes appear on the third rising system clock edge after it. This delay covers the two synchronizer flops and the edge register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the initiator |
| sload | input | 1 | Load strobe, high on the last bit of a frame |
| sdout | input | 1 | Outbound serial data from the initiator |
| tgt_status | input | 3*NSLOT | Per-slot status returned on the inbound line |
| sdin | output | 1 | Inbound serial data to the initiator |
| act | output | NSLOT | Latched activity bit per slot |
| loc | output | NSLOT | Latched locate bit per slot |
| fail | output | NSLOT | Latched fail bit per slot |
| frame_ok | output | 1 | One-cycle pulse when a complete frame is committed |
| frame_err | output | 1 | One-cycle pulse when a frame of wrong length is dropped |

## Verification
Two things share one falling serial edge: committing a finished frame, and rewinding the bit index that also selects the inbound bit. The bench provokes this by sending frames back to back with no idle bits. It then judges both results, expecting the commit pulse on the third system clock after the edge. It also expects the next rising edge to return slot 0's activity status, not a bit left over from the old index. Truncated and over-long frames placed between good frames show that the error path neither commits data nor loses the alignment of the next frame.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
  localparam int unsigned FIELDS  = 3;
  localparam int unsigned F_ACT   = 0;
  localparam int unsigned F_LOC   = 1;
  localparam int unsigned F_FAIL  = 2;

  // position of a slot's field in a frame-ordered bit vector
  function automatic int unsigned bit_pos(int unsigned slot, int unsigned field);
    return slot * FIELDS + field;
  endfunction

  // number of bits carried by a frame of nslot slots
  function automatic int unsigned frame_bits(int unsigned nslot);
    return nslot * FIELDS;
  endfunction
endpackage

// File: rtl/sgr_sync.sv
module sgr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/sgr_edge.sv
module sgr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sgr_framer.sv
module sgr_framer
  import sgr_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned NB   = frame_bits(NSLOT),
  localparam int unsigned CW   = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic             ld,
  input  logic             din,
  output logic [CW-1:0]    bit_idx,
  output logic [NSLOT-1:0] act,
  output logic [NSLOT-1:0] loc,
  output logic [NSLOT-1:0] fail,
  output logic             frame_ok,
  output logic             frame_err
);
  logic [NB-1:0] shadow_q, shadow_nx, frame_q;
  logic [CW-1:0] cnt_q;
  logic          synced_q, ok_q, err_q;
  logic          len_ok;

  // merge the bit being sampled now into the collected frame
  always_comb begin
    shadow_nx = shadow_q;
    if (cnt_q < CW'(NB)) shadow_nx[cnt_q] = din;
  end

  assign len_ok = (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      frame_q  <= '0;
      cnt_q    <= '0;
      synced_q <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (fall_evt) begin
        shadow_q <= shadow_nx;
        if (ld) begin
          cnt_q    <= '0;
          synced_q <= 1'b1;
          if (synced_q) begin
            if (len_ok) begin
              frame_q <= shadow_nx;
              ok_q    <= 1'b1;
            end else begin
              err_q <= 1'b1;
            end
          end
        end else if (cnt_q != CW'(NB)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign act[s]  = frame_q[bit_pos(s, F_ACT)];
    assign loc[s]  = frame_q[bit_pos(s, F_LOC)];
    assign fail[s] = frame_q[bit_pos(s, F_FAIL)];
  end

  assign bit_idx   = cnt_q;
  assign frame_ok  = ok_q;
  assign frame_err = err_q;
endmodule

// File: rtl/sgr_inbound.sv
module sgr_inbound
  import sgr_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter bit          HAS_IN = 1'b1,
  localparam int unsigned NB    = frame_bits(NSLOT),
  localparam int unsigned CW    = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_evt,
  input  logic [CW-1:0] bit_idx,
  input  logic [NB-1:0] tgt_status,
  output logic          sdin
);
  if (HAS_IN) begin : g_drive
    logic sdin_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        sdin_q <= 1'b0;
      else if (rise_evt) sdin_q <= (bit_idx < CW'(NB)) ? tgt_status[bit_idx] : 1'b0;
    end
    assign sdin = sdin_q;
  end else begin : g_tie
    logic unused_in;
    assign unused_in = ^{clk, rst_n, rise_evt, bit_idx, tgt_status};
    assign sdin = 1'b0;
  end
endmodule

// File: rtl/sgpio_rx.sv
module sgpio_rx
  import sgr_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter bit          HAS_IN = 1'b1,
  localparam int unsigned NB    = frame_bits(NSLOT),
  localparam int unsigned CW    = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sload,
  input  logic             sdout,
  input  logic [NB-1:0]    tgt_status,
  output logic             sdin,
  output logic [NSLOT-1:0] act,
  output logic [NSLOT-1:0] loc,
  output logic [NSLOT-1:0] fail,
  output logic             frame_ok,
  output logic             frame_err
);
  logic          sclk_s, ld_s, d_s;
  logic          rise_evt, fall_evt;
  logic [CW-1:0] bit_idx;

  sgr_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, sload, sdout}),
    .q({sclk_s, ld_s, d_s})
  );

  sgr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s),
    .rise(rise_evt), .fall(fall_evt)
  );

  sgr_framer #(.NSLOT(NSLOT)) u_framer (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .ld(ld_s), .din(d_s),
    .bit_idx(bit_idx), .act(act), .loc(loc), .fail(fail),
    .frame_ok(frame_ok), .frame_err(frame_err)
  );

  sgr_inbound #(.NSLOT(NSLOT), .HAS_IN(HAS_IN)) u_inbound (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .bit_idx(bit_idx),
    .tgt_status(tgt_status), .sdin(sdin)
  );
endmodule

// File: rtl/sgpio_rx_chk.sv
module sgpio_rx_chk #(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned NB   = NSLOT * 3,
  localparam int unsigned CW   = $clog2(NB + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic [CW-1:0]    bit_idx,
  input logic [NSLOT-1:0] act,
  input logic [NSLOT-1:0] loc,
  input logic [NSLOT-1:0] fail,
  input logic             frame_ok,
  input logic             frame_err,
  input logic             sdin
);
  // R3
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));
  // R3
  ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  // R3
  ok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(fall_evt));
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(fall_evt));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> $stable({act, loc, fail}));
  // R7
  sdin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdin) |-> $past(rise_evt));
  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= CW'(NB));
endmodule

bind sgpio_rx sgpio_rx_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .bit_idx(bit_idx), .act(act), .loc(loc), .fail(fail),
  .frame_ok(frame_ok), .frame_err(frame_err), .sdin(sdin)
);

// File: tb/sim_sgpio_rx.sv
module sim_sgpio_rx;
  localparam int N  = 4;
  localparam int NB = 3 * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sload = 1'b0, sdout = 1'b0;
  logic [NB-1:0] tgt = '0;
  logic sdin0, ok0, err0;
  logic [N-1:0] act0, loc0, fail0;
  logic sdin1, ok1, err1;
  logic [N-1:0] act1, loc1, fail1;

  always #4 clk = ~clk;

  sgpio_rx #(.NSLOT(N), .HAS_IN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sload(sload), .sdout(sdout),
    .tgt_status(tgt), .sdin(sdin0), .act(act0), .loc(loc0), .fail(fail0),
    .frame_ok(ok0), .frame_err(err0));

  sgpio_rx #(.NSLOT(N), .HAS_IN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sload(sload), .sdout(sdout),
    .tgt_status(tgt), .sdin(sdin1), .act(act1), .loc(loc1), .fail(fail1),
    .frame_ok(ok1), .frame_err(err1));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  bit q[$];
  bit synced = 0;
  logic [N-1:0] e_act = '0, e_loc = '0, e_fail = '0;
  bit p_ok, p_err;

  task automatic chk(bit good, string req, string what, int got, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // reference: one sampled bit on a falling serial edge
  task automatic model_fall();
    p_ok = 0; p_err = 0;
    q.push_back(sdout);
    if (sload) begin
      if (synced) begin
        if (q.size() == NB) begin
          for (int s = 0; s < N; s++) begin
            e_act[s]  = q[3*s];
            e_loc[s]  = q[3*s+1];
            e_fail[s] = q[3*s+2];
          end
          p_ok = 1;
        end else p_err = 1;
      end
      synced = 1;
      q.delete();
    end
  endtask

  task automatic compare(bit xok, bit xerr);
    chk(ok0 == xok,   {tag, " R3 R9"}, "frame_ok", ok0, xok);
    chk(err0 == xerr, {tag, " R4 R9"}, "frame_err", err0, xerr);
    chk(act0 == e_act,  {tag, " R2 R6"}, "act", act0, e_act);
    chk(loc0 == e_loc,  {tag, " R2 R6"}, "loc", loc0, e_loc);
    chk(fail0 == e_fail, {tag, " R2 R6"}, "fail", fail0, e_fail);
    chk(sdin1 == 1'b0, "R8", "tied sdin", sdin1, 0);
  endtask

  task automatic half(bit lvl, bit ld, bit d);
    sclk = lvl;
    if (lvl) begin sload = ld; sdout = d; end
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 3 && !lvl) begin
        model_fall();
        compare(p_ok, p_err);
      end else compare(0, 0);
      if (i == 4 && lvl) begin
        bit xs;
        xs = (q.size() < NB) ? tgt[q.size()] : 1'b0;
        chk(sdin0 == xs, {tag, " R7"}, "sdin", sdin0, xs);
      end
    end
  endtask

  task automatic send_frame(int n, logic [31:0] pat);
    for (int j = 0; j < n; j++) begin
      half(1, j == n - 1, pat[j]);
      half(0, j == n - 1, pat[j]);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(act0 == 0 && loc0 == 0 && fail0 == 0, "R1", "slot outputs", act0, 0);
    chk(ok0 == 0 && err0 == 0, "R1", "pulses", ok0, 0);
    chk(sdin0 == 0, "R1", "sdin", sdin0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare(0, 0);
    tgt = 12'hA5C;
    // R5: first frame only aligns
    tag = "R5";
    send_frame(NB, 32'hFFF);
    chk(act0 == 0 && fail0 == 0, "R5", "after unsynced frame", act0, 0);
    tag = "R3";
    send_frame(NB, 32'hFFF);
    tgt = 12'h3C9;
    send_frame(NB, 32'h5A3);  // back to back, inbound rewinds
    tag = "R4";
    send_frame(9, 32'h1FF);   // truncated
    tag = "R3";
    send_frame(NB, 32'h3C6);
    tag = "R4";
    send_frame(15, 32'h7FFF); // over-long
    tgt = 12'h924;
    tag = "R2";
    send_frame(NB, 32'h924);
    send_frame(NB, 32'h000);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule